// File: doc/BRIEF.md
# Prefixed Move-Instruction Decoder

This block decodes the 16-bit move instructions of a transport-triggered core. Every instruction is a single transfer. A format bit selects whether the source is an immediate byte or a register named by a module and an index. The destination is always a register, named by a module and a three-bit subindex. The decoded fields come out one clock after the instruction is accepted.

Some destinations lie above the eight that the subindex can name directly, and some immediates are wider than a byte. To reach them, the core first executes a prefix write: a move of an immediate byte into the prefix module. That write leaves two extra destination index bits and an upper immediate byte pending, and the next accepted instruction uses them. The pending value then returns to zero. Cycles with no valid instruction do not use up a pending prefix. The decoder never stalls. It tells the consumer whether a prefix was applied, and it marks the prefix write itself so that the consumer can skip that instruction.

Top module: `mvdec_top`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` is high, and low in the cycle after a cycle in which `in_valid` is low.
- R2: When instruction bit 15 is 0, the source is immediate. `out_src_imm` is then 1 and `out_imm[7:0]` equals instruction bits 7:0. When bit 15 is 1, `out_src_imm` is 0.
- R3: `out_src_mod` equals instruction bits 3:0 and `out_src_reg` equals instruction bits 7:4.
- R4: `out_dst_mod` equals instruction bits 11:8 and `out_dst_reg[2:0]` equals instruction bits 14:12.
- R5: An instruction is a prefix write when all of these hold: bit 15 is 0, bits 11:8 equal the prefix module (default 4'hB), and bits 14:12 are below 4. A prefix write decodes with `out_is_pfx` = 1.
- R6: The valid instruction that follows a prefix write decodes with `out_pfx_used` = 1. Its `out_dst_reg[4:3]` equals bits 13:12 of the prefix write, and its `out_imm[15:8]` equals bits 7:0 of the prefix write.
- R7: A prefix applies to exactly one following valid instruction. Cycles with `in_valid` low in between do not use it up.
- R8: When no prefix is pending, `out_pfx_used` is 0 and both `out_dst_reg[4:3]` and `out_imm[15:8]` are 0.
- R9: Reset clears every output to 0 and drops any pending prefix.
- R10: A register-format write to the prefix module, or a write to prefix-module subindex 4 to 7, is an ordinary move. It sets no prefix and decodes with `out_is_pfx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| in_instr | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields are valid |
| out_src_imm | output | 1 | Source is immediate |
| out_src_mod | output | 4 | Source module |
| out_src_reg | output | 4 | Source register index |
| out_imm | output | 16 | Immediate value, upper byte taken from the prefix |
| out_dst_mod | output | 4 | Destination module |
| out_dst_reg | output | 5 | Extended destination register index |
| out_pfx_used | output | 1 | A pending prefix was applied to this instruction |
| out_is_pfx | output | 1 | This instruction is itself a prefix write |

## Verification
If the pending-prefix state is wrong, it shows on the very next valid decode. A prefix that was lost shows `out_pfx_used` low with zero upper bits. A prefix that sticks shows nonzero `out_dst_reg[4:3]` or `out_imm[15:8]` on an instruction two or more after the prefix write. If idle cycles wrongly use up a prefix, the fault appears only when a gap separates a prefix from the instruction it applies to, so the stimulus puts gaps in that position deliberately. The bench also checks the recognition boundaries: subindex 3 against subindex 4, immediate format against register format, and back-to-back prefix writes.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;
    localparam int INSTR_W     = 16;
    localparam int MOD_W       = 4;
    localparam int REG_W       = 4;
    localparam int SUB_W       = 3;
    localparam int BYTE_W      = 8;
    localparam int FMT_BIT     = 15;
    localparam int DST_SUB_LSB = 12;
    localparam int DST_MOD_LSB = 8;
    localparam int SRC_REG_LSB = 4;
    localparam int SRC_MOD_LSB = 0;

    typedef struct packed {
        logic              src_imm;
        logic [MOD_W-1:0]  src_mod;
        logic [REG_W-1:0]  src_reg;
        logic [BYTE_W-1:0] src_byte;
        logic [MOD_W-1:0]  dst_mod;
        logic [SUB_W-1:0]  dst_sub;
        logic              pfx_wr;
    } raw_fields_t;
endpackage

// File: rtl/mvdec_fields.sv
module mvdec_fields
    import mvdec_pkg::*;
#(
    parameter logic [MOD_W-1:0] PFX_MOD   = 4'hB,
    parameter int               PFX_EXT_W = 2
) (
    input  logic [INSTR_W-1:0] instr,
    output raw_fields_t        fields
);
    localparam int PFX_REGS = 1 << PFX_EXT_W;

    always_comb begin
        fields          = '0;
        fields.src_imm  = ~instr[FMT_BIT];
        fields.src_mod  = instr[SRC_MOD_LSB +: MOD_W];
        fields.src_reg  = instr[SRC_REG_LSB +: REG_W];
        fields.src_byte = instr[0 +: BYTE_W];
        fields.dst_mod  = instr[DST_MOD_LSB +: MOD_W];
        fields.dst_sub  = instr[DST_SUB_LSB +: SUB_W];
        fields.pfx_wr   = fields.src_imm
                        && (fields.dst_mod == PFX_MOD)
                        && (int'(fields.dst_sub) < PFX_REGS);
    end
endmodule

// File: rtl/mvdec_prefix.sv
module mvdec_prefix
    import mvdec_pkg::*;
#(
    parameter int PFX_EXT_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  raw_fields_t          fields,
    output logic                 pend,
    output logic [PFX_EXT_W-1:0] ext,
    output logic [BYTE_W-1:0]    hi
);
    typedef struct packed {
        logic                 pend;
        logic [PFX_EXT_W-1:0] ext;
        logic [BYTE_W-1:0]    hi;
    } pfx_state_t;

    pfx_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (adv) begin
            if (fields.pfx_wr) begin
                state_d.pend = 1'b1;
                state_d.ext  = fields.dst_sub[PFX_EXT_W-1:0];
                state_d.hi   = fields.src_byte;
            end else begin
                state_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pend = state_q.pend;
    assign ext  = state_q.ext;
    assign hi   = state_q.hi;
endmodule

// File: rtl/mvdec_outstage.sv
module mvdec_outstage
    import mvdec_pkg::*;
#(
    parameter int PFX_EXT_W = 2,
    parameter int DST_W     = SUB_W + PFX_EXT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  raw_fields_t          fields,
    input  logic                 pend,
    input  logic [PFX_EXT_W-1:0] ext,
    input  logic [BYTE_W-1:0]    hi,
    output logic                 o_valid,
    output logic                 o_src_imm,
    output logic [MOD_W-1:0]     o_src_mod,
    output logic [REG_W-1:0]     o_src_reg,
    output logic [2*BYTE_W-1:0]  o_imm,
    output logic [MOD_W-1:0]     o_dst_mod,
    output logic [DST_W-1:0]     o_dst_reg,
    output logic                 o_pfx_used,
    output logic                 o_is_pfx
);
    typedef struct packed {
        logic                valid;
        logic                src_imm;
        logic [MOD_W-1:0]    src_mod;
        logic [REG_W-1:0]    src_reg;
        logic [2*BYTE_W-1:0] imm;
        logic [MOD_W-1:0]    dst_mod;
        logic [DST_W-1:0]    dst_reg;
        logic                pfx_used;
        logic                is_pfx;
    } dec_out_t;

    dec_out_t out_d, out_q;
    logic [PFX_EXT_W-1:0] ext_eff;
    logic [BYTE_W-1:0]    hi_eff;

    always_comb begin
        ext_eff = pend ? ext : '0;
        hi_eff  = pend ? hi  : '0;
        out_d       = out_q;
        out_d.valid = adv;
        if (adv) begin
            out_d.src_imm  = fields.src_imm;
            out_d.src_mod  = fields.src_mod;
            out_d.src_reg  = fields.src_reg;
            out_d.imm      = {hi_eff, fields.src_byte};
            out_d.dst_mod  = fields.dst_mod;
            out_d.dst_reg  = {ext_eff, fields.dst_sub};
            out_d.pfx_used = pend;
            out_d.is_pfx   = fields.pfx_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign o_valid    = out_q.valid;
    assign o_src_imm  = out_q.src_imm;
    assign o_src_mod  = out_q.src_mod;
    assign o_src_reg  = out_q.src_reg;
    assign o_imm      = out_q.imm;
    assign o_dst_mod  = out_q.dst_mod;
    assign o_dst_reg  = out_q.dst_reg;
    assign o_pfx_used = out_q.pfx_used;
    assign o_is_pfx   = out_q.is_pfx;
endmodule

// File: rtl/mvdec_top.sv
module mvdec_top
    import mvdec_pkg::*;
#(
    parameter logic [3:0] PFX_MOD   = 4'hB,
    parameter int         PFX_EXT_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [15:0]                  in_instr,
    output logic                         out_valid,
    output logic                         out_src_imm,
    output logic [3:0]                   out_src_mod,
    output logic [3:0]                   out_src_reg,
    output logic [15:0]                  out_imm,
    output logic [3:0]                   out_dst_mod,
    output logic [SUB_W+PFX_EXT_W-1:0]   out_dst_reg,
    output logic                         out_pfx_used,
    output logic                         out_is_pfx
);
    localparam int DST_W = SUB_W + PFX_EXT_W;

    raw_fields_t          fields;
    logic                 pend;
    logic [PFX_EXT_W-1:0] ext;
    logic [BYTE_W-1:0]    hi;

    mvdec_fields #(.PFX_MOD(PFX_MOD), .PFX_EXT_W(PFX_EXT_W)) fields_i (
        .instr  (in_instr),
        .fields (fields)
    );

    mvdec_prefix #(.PFX_EXT_W(PFX_EXT_W)) prefix_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (in_valid),
        .fields (fields),
        .pend   (pend),
        .ext    (ext),
        .hi     (hi)
    );

    mvdec_outstage #(.PFX_EXT_W(PFX_EXT_W), .DST_W(DST_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (in_valid),
        .fields     (fields),
        .pend       (pend),
        .ext        (ext),
        .hi         (hi),
        .o_valid    (out_valid),
        .o_src_imm  (out_src_imm),
        .o_src_mod  (out_src_mod),
        .o_src_reg  (out_src_reg),
        .o_imm      (out_imm),
        .o_dst_mod  (out_dst_mod),
        .o_dst_reg  (out_dst_reg),
        .o_pfx_used (out_pfx_used),
        .o_is_pfx   (out_is_pfx)
    );
endmodule

// File: rtl/mvdec_checker.sv
module mvdec_checker #(
    parameter logic [3:0] PFX_MOD   = 4'hB,
    parameter int         PFX_EXT_W = 2,
    parameter int         DST_W     = 3 + PFX_EXT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [15:0]      in_instr,
    input logic             out_valid,
    input logic             out_src_imm,
    input logic [3:0]       out_src_mod,
    input logic [3:0]       out_src_reg,
    input logic [15:0]      out_imm,
    input logic [3:0]       out_dst_mod,
    input logic [DST_W-1:0] out_dst_reg,
    input logic             out_pfx_used,
    input logic             out_is_pfx
);
    localparam int PFX_REGS = 1 << PFX_EXT_W;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_imm_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_src_imm == !$past(in_instr[15])));
    assert_imm_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_imm[7:0] == $past(in_instr[7:0])));
    assert_src_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_src_mod == $past(in_instr[3:0]) && out_src_reg == $past(in_instr[7:4])));
    assert_dst_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dst_mod == $past(in_instr[11:8]) && out_dst_reg[2:0] == $past(in_instr[14:12])));
    assert_pfx_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_instr[15] && in_instr[11:8] == PFX_MOD && int'(in_instr[14:12]) < PFX_REGS)
        |=> out_is_pfx);
    assert_pfx_applied_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_valid && out_is_pfx) |=> out_pfx_used);
    assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_valid && !out_is_pfx) |=> !out_pfx_used);
    assert_zero_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_pfx_used) |-> (out_dst_reg[DST_W-1:3] == '0 && out_imm[15:8] == 8'h00));
    assert_reg_fmt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_instr[15]) |=> !out_is_pfx);
endmodule

bind mvdec_top mvdec_checker #(.PFX_MOD(PFX_MOD), .PFX_EXT_W(PFX_EXT_W), .DST_W(DST_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_instr     (in_instr),
    .out_valid    (out_valid),
    .out_src_imm  (out_src_imm),
    .out_src_mod  (out_src_mod),
    .out_src_reg  (out_src_reg),
    .out_imm      (out_imm),
    .out_dst_mod  (out_dst_mod),
    .out_dst_reg  (out_dst_reg),
    .out_pfx_used (out_pfx_used),
    .out_is_pfx   (out_is_pfx)
);

// File: tb/mvdec_top_tb_top.sv
`timescale 1ns/1ps
module mvdec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic        out_valid, out_src_imm, out_pfx_used, out_is_pfx;
    logic [3:0]  out_src_mod, out_src_reg, out_dst_mod;
    logic [15:0] out_imm;
    logic [4:0]  out_dst_reg;

    int errors = 0;
    int checks = 0;

    // bench model of the pending prefix
    logic       m_pend = 1'b0;
    logic [1:0] m_ext = '0;
    logic [7:0] m_hi = '0;

    always #5 clk = ~clk;

    mvdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .out_valid(out_valid), .out_src_imm(out_src_imm), .out_src_mod(out_src_mod),
        .out_src_reg(out_src_reg), .out_imm(out_imm), .out_dst_mod(out_dst_mod),
        .out_dst_reg(out_dst_reg), .out_pfx_used(out_pfx_used), .out_is_pfx(out_is_pfx)
    );

    function automatic logic is_pfx_word(input logic [15:0] w);
        return !w[15] && w[11:8] == 4'hB && w[14:12] < 3'd4;
    endfunction

    function automatic logic [35:0] expect_word(input logic [15:0] w, input logic pend,
                                                input logic [1:0] ext, input logic [7:0] hi);
        logic [7:0] h = pend ? hi : 8'h00;
        logic [1:0] e = pend ? ext : 2'b00;
        return {!w[15], w[3:0], w[7:4], h, w[7:0], w[11:8], e, w[14:12], pend, is_pfx_word(w)};
    endfunction

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] outs();
        return {out_src_imm, out_src_mod, out_src_reg, out_imm, out_dst_mod,
                out_dst_reg, out_pfx_used, out_is_pfx};
    endfunction

    // drive one cycle at a falling edge, check at the next falling edge
    task automatic step(input logic v, input logic [15:0] w, input string tag);
        logic [35:0] e;
        e = expect_word(w, m_pend, m_ext, m_hi);
        in_valid = v;
        in_instr = w;
        if (v) begin
            if (is_pfx_word(w)) begin
                m_pend = 1'b1; m_ext = w[13:12]; m_hi = w[7:0];
            end else begin
                m_pend = 1'b0; m_ext = '0; m_hi = '0;
            end
        end
        @(negedge clk);
        chk("R1 valid", {35'd0, out_valid}, {35'd0, v});
        if (v) chk(tag, outs(), e);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        m_pend = 1'b0; m_ext = '0; m_hi = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 reset outputs", {outs()[35:0]}, 36'd0);
        chk("R9 reset valid", {35'd0, out_valid}, 36'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R2 immediate source, R3 register source, R4 destination fields
        step(1, 16'h35A7, "R2 immediate");
        step(1, 16'hC2F3, "R3 register source");
        step(1, 16'h7E10, "R4 dst top subindex");
        // R5 prefix write subindex 2, byte 5C, then R6 applied
        step(1, 16'h2B5C, "R5 prefix write");
        step(1, 16'h5304, "R6 prefix applied");
        step(1, 16'h5304, "R7 prefix consumed");
        // R7 idle cycles keep the prefix
        step(1, 16'h3BFF, "R5 prefix sub3");
        step(0, 16'h0000, "R7 idle");
        step(0, 16'hFFFF, "R7 idle");
        step(1, 16'hE1A2, "R7 prefix after gap");
        step(1, 16'h0011, "R8 no prefix");
        // back-to-back prefix writes
        step(1, 16'h1B01, "R5 first prefix");
        step(1, 16'h0B02, "R6 prefix on prefix");
        step(1, 16'h4022, "R6 second prefix applied");
        // R10 boundaries
        step(1, 16'hBB33, "R10 register format to prefix module");
        step(1, 16'h0155, "R10 no prefix after reg fmt");
        step(1, 16'h4B44, "R10 subindex 4");
        step(1, 16'h0155, "R10 no prefix after sub4");
        // R9 reset drops a pending prefix
        step(1, 16'h3B77, "R5 prefix before reset");
        do_reset();
        step(1, 16'h2099, "R9 no prefix after reset");
        // random mix
        void'($urandom(32'h5EED));
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] w = 16'($urandom());
            logic v = ($urandom() % 5) != 0;
            if ($urandom() % 3 == 0) w = {2'b00, 2'($urandom()), 4'hB, 8'($urandom())};
            step(v, w, m_pend ? "R6 random" : "R8 random");
        end
        in_valid = 1'b0;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule